// File: doc/BRIEF.md
# PWM Channel Idle and Power-State Controller

This block sits between a per-channel PWM duty-cycle converter and the analog output stage of a PWM-to-voltage converter. For every channel it decides what the output stage presents: the most recently converted code, zero-scale, full-scale, a held code, or a powered-down output with high impedance. It also decides whether the shared voltage reference runs.

The decision draws on several inputs. The first is a timer per channel that counts clock cycles since the last PWM rising edge. The others are the PWM level at the moment that timer expires, a policy select pin and an active-low power-down pin. With the policy select low (transparent policy), an idle input drives the output to the rail it idles at. With the policy select high (sample/hold policy), a code is kept indefinitely while the input idles high. In that policy the output goes dark when the input idles low, and a fresh pair of close rising edges is needed before a new code is accepted.

The converter supplies a code and a one-cycle valid strobe after each rising edge. This block accepts that strobe only when the edge before it came soon enough after the previous edge.

Top module: `pwm_idle_ctl`

## Requirements
- R1: With T = (CLK_HZ/1000)*TIMEOUT_MS, a channel enters its idle state on the T-th clock edge after the edge that captured its last rising-edge pulse. Before that edge its outputs do not change.
- R2: After reset with the policy select low, every channel shows code 0 with out_en 1.
- R3: Under the transparent policy, idling with the PWM level low shows code 0 with out_en 1. Idling with the level high shows the all-ones code with out_en 1.
- R4: Under the sample/hold policy, reset and idling low both give out_en 0 with code_out 0. Idling high keeps the last accepted code with out_en 1.
- R5: A code strobe is accepted, and appears on code_out the cycle after it is captured, only when the two latest rising edges were at most T cycles apart. Edges further apart are ignored.
- R6: Once a channel is idle, a falling PWM level restarts its timer. T cycles later the channel re-idles under the low-level policy.
- R7: The power-down pin passes through a two-flop synchronizer. While it is low, every channel has out_en 0 and code 0. Under the transparent policy, releasing it restores the previous outputs at once.
- R8: Under the sample/hold policy, after power-down a channel stays dark through a single rising edge with a strobe. It updates only after a second rising edge within T cycles, followed by a strobe.
- R9: ref_en is 0 when ext_ref is high, when power-down is active, or when no channel has out_en set. Otherwise it is 1.
- R10: The policy select is synchronized. A channel adopts a new policy only at its next idle or update event, and the displayed or held code is not disturbed by the change. Until its first event after reset, a channel follows the reset state of the current policy.
- R11: Channels are independent. Edges and strobes on one channel leave the other channel's outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| pwm_lvl | input | NCH | Synchronized PWM level per channel |
| pwm_rise | input | NCH | One-cycle rising-edge pulse per channel |
| code_vld | input | NCH | Converter code-valid strobe per channel |
| code_in | input | NCH*CODE_W | Converter codes, channel 0 in the low bits |
| hold_mode | input | 1 | Policy select: 0 transparent, 1 sample/hold |
| pd_n | input | 1 | Active-low power-down |
| ext_ref | input | 1 | High when an external reference is used |
| code_out | output | NCH*CODE_W | Effective code per channel |
| out_en | output | NCH | Output stage enabled (0 = high impedance) |
| ref_en | output | 1 | Internal reference enable |

## Verification
Two kinds of state error are possible. A stale armed flag lets a widely spaced edge pair load a new code. A missed armed flag drops a valid update. Either one shows on code_out the cycle after the strobe. A timer that is off by one moves the switch to the idle-state code by one cycle, so the bench samples both sides of the exact idle edge after a rise and after a fall. A policy latched at the wrong time shows up at the next idle event as the wrong rail, or as a dark output where a held code was expected.

// File: rtl/pwm_idle_ctl.sv
module pwm_idle_ctl #(
  parameter int NCH        = 2,
  parameter int CODE_W     = 12,
  parameter int CLK_HZ     = 1_000_000,
  parameter int TIMEOUT_MS = 60
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          pwm_lvl,
  input  logic [NCH-1:0]          pwm_rise,
  input  logic [NCH-1:0]          code_vld,
  input  logic [NCH*CODE_W-1:0]   code_in,
  input  logic                    hold_mode,
  input  logic                    pd_n,
  input  logic                    ext_ref,
  output logic [NCH*CODE_W-1:0]   code_out,
  output logic [NCH-1:0]          out_en,
  output logic                    ref_en
);
  localparam int TO_CYC = (CLK_HZ / 1000) * TIMEOUT_MS;
  localparam int CW     = $clog2(TO_CYC + 1);
  localparam logic [CW-1:0] T_END  = CW'(TO_CYC);
  localparam logic [CW-1:0] T_LAST = CW'(TO_CYC - 1);

  logic [1:0] mode_q, pd_q, ext_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= 2'b00;
      pd_q   <= 2'b11;
      ext_q  <= 2'b00;
    end else begin
      mode_q <= {mode_q[0], hold_mode};
      pd_q   <= {pd_q[0], pd_n};
      ext_q  <= {ext_q[0], ext_ref};
    end

  wire mode_s = mode_q[1];
  wire pd_s   = ~pd_q[1];
  wire ext_s  = ext_q[1];

  logic [NCH-1:0] oe_int;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [CW-1:0]     cnt;
    logic              recent, armed, idle, idle_hi, pol, por, have, lvl_q, oe;
    logic [CODE_W-1:0] code_r, shown;

    wire expired = (cnt == T_END);
    wire fall    = lvl_q & ~pwm_lvl[ch];
    wire dark_pd = pd_s & mode_s;
    wire tick    = (cnt == T_LAST) & ~pwm_rise[ch];
    wire take    = code_vld[ch] & armed;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt <= T_END; recent <= 1'b0; armed <= 1'b0; idle <= 1'b1;
        idle_hi <= 1'b0; pol <= 1'b0; por <= 1'b1; have <= 1'b0;
        lvl_q <= 1'b0; code_r <= '0;
      end else begin
        lvl_q <= pwm_lvl[ch];
        if (por) pol <= mode_s;
        if (dark_pd) begin
          cnt <= T_END; recent <= 1'b0; armed <= 1'b0; idle <= 1'b1;
          idle_hi <= 1'b0; pol <= 1'b1; por <= 1'b0; have <= 1'b0;
        end else begin
          if (pwm_rise[ch]) begin
            cnt <= '0; recent <= 1'b1; armed <= recent;
          end else if (expired && fall) cnt <= '0;
          else if (!expired) cnt <= cnt + CW'(1);
          if (tick) begin
            recent <= 1'b0; armed <= 1'b0; idle <= 1'b1;
            idle_hi <= pwm_lvl[ch]; pol <= mode_s; por <= 1'b0;
          end
          if (take) begin
            code_r <= code_in[ch*CODE_W +: CODE_W];
            idle <= 1'b0; pol <= mode_s; por <= 1'b0; have <= 1'b1;
            if (!pwm_rise[ch]) armed <= 1'b0;
          end
        end
      end

    always_comb begin
      oe    = 1'b1;
      shown = code_r;
      if (idle) begin
        if (!pol)                  shown = idle_hi ? {CODE_W{1'b1}} : '0;
        else if (!(idle_hi && have)) begin
          oe    = 1'b0;
          shown = '0;
        end
      end
    end

    assign oe_int[ch] = oe;
    assign out_en[ch] = oe & ~pd_s;
    assign code_out[ch*CODE_W +: CODE_W] = pd_s ? '0 : shown;

    AST_IDLE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !dark_pd) |=> idle); // R1
    AST_FAR_PAIR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (code_vld[ch] && !armed) |=> $stable(code_r)); // R5
    AST_PD_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_s && $past(pd_s)) |-> (code_out[ch*CODE_W +: CODE_W] == '0 && !out_en[ch])); // R7
    AST_SH_PD_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      dark_pd |=> (!armed && !have)); // R8
  end

  assign ref_en = ~pd_s & ~ext_s & (|oe_int);

  AST_REF_NEEDS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    ref_en |-> (|out_en)); // R9
endmodule

// File: tb/sim_pwm_idle_ctl.sv
module sim_pwm_idle_ctl;
  localparam int CLK_PER = 10;
  localparam int NCH = 2;
  localparam int W = 8;
  localparam int T = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] lvl = '0, rise = '0, vld = '0;
  logic [NCH*W-1:0] cin = '0;
  logic hold_mode = 1'b0, pd_n = 1'b1, ext_ref = 1'b0;
  logic [NCH*W-1:0] code_out;
  logic [NCH-1:0] out_en;
  logic ref_en;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  pwm_idle_ctl #(.NCH(NCH), .CODE_W(W), .CLK_HZ(1000), .TIMEOUT_MS(60)) u0 (
    .clk(clk), .rst_n(rst_n), .pwm_lvl(lvl), .pwm_rise(rise), .code_vld(vld),
    .code_in(cin), .hold_mode(hold_mode), .pd_n(pd_n), .ext_ref(ext_ref),
    .code_out(code_out), .out_en(out_en), .ref_en(ref_en));

  function automatic int exp_pair(int g, bit sh, int c);
    if (g <= T) return 256 + c;
    return sh ? 0 : 256;
  endfunction

  task automatic chk(string req, int got, int expv);
    total++;
    if (got !== expv) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, expv);
    end
  endtask

  function automatic int st(int ch);
    return {23'd0, out_en[ch], code_out[ch*W +: W]};
  endfunction

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_pair(int ch, int g, logic [W-1:0] c);
    @(negedge clk); lvl[ch] = 1; rise[ch] = 1;
    for (int k = 1; k <= g; k++) begin
      @(negedge clk); rise[ch] = (k == g); lvl[ch] = (k < 3) || (k == g);
    end
    @(negedge clk); rise[ch] = 0; vld[ch] = 1; cin[ch*W +: W] = c;
    @(negedge clk); vld[ch] = 0; lvl[ch] = 0;
  endtask

  task automatic single(int ch, logic [W-1:0] c);
    @(negedge clk); lvl[ch] = 1; rise[ch] = 1;
    @(negedge clk); rise[ch] = 0; vld[ch] = 1; cin[ch*W +: W] = c;
    @(negedge clk); vld[ch] = 0; lvl[ch] = 0;
  endtask

  task automatic rise_hold(int ch);
    @(negedge clk); lvl[ch] = 1; rise[ch] = 1;
    @(negedge clk); rise[ch] = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    wait_n(3); rst_n = 1; wait_n(4);
    chk("R2 ch0", st(0), 256); chk("R2 ch1", st(1), 256);
    chk("R9 ref on", ref_en, 1);

    run_pair(0, 20, 8'hA5);
    chk("R5 close pair", st(0), 256 + 8'hA5);
    chk("R11 ch1 untouched", st(1), 256);

    rise_hold(0); wait_n(T - 1);
    chk("R1 before limit", st(0), 256 + 8'hA5);
    wait_n(1);
    chk("R3 idle high full", st(0), 256 + 8'hFF);
    @(negedge clk); lvl[0] = 0; wait_n(T);
    chk("R6 before refall limit", st(0), 256 + 8'hFF);
    wait_n(1);
    chk("R6 R3 idle low zero", st(0), 256);

    run_pair(0, 10, 8'h3C);
    @(negedge clk); pd_n = 0; wait_n(3);
    chk("R7 pd ch0", st(0), 0); chk("R7 pd ch1", st(1), 0);
    chk("R9 pd ref off", ref_en, 0);
    pd_n = 1; wait_n(3);
    chk("R7 release restores", st(0), 256 + 8'h3C);
    ext_ref = 1; wait_n(3);
    chk("R9 ext ref off", ref_en, 0);
    ext_ref = 0; wait_n(3);
    chk("R9 ref back", ref_en, 1);

    hold_mode = 1; wait_n(3);
    chk("R10 code kept on mode change", st(0), 256 + 8'h3C);
    wait_n(T + 5);
    chk("R10 R4 new policy at idle", st(0), 0);
    chk("R9 both dark ref off", ref_en, 0);

    run_pair(0, 30, 8'h5A);
    chk("R5 sh close pair", st(0), 256 + 8'h5A);
    rise_hold(0); wait_n(T + 2);
    chk("R4 idle high hold", st(0), 256 + 8'h5A);
    hold_mode = 0; wait_n(3);
    chk("R10 held code intact", st(0), 256 + 8'h5A);
    hold_mode = 1; wait_n(3);
    @(negedge clk); lvl[0] = 0; wait_n(T + 2);
    chk("R4 R6 idle low dark", st(0), 0);

    run_pair(0, T + 1, 8'h11);
    chk("R5 gap T+1 ignored", st(0), 0);
    run_pair(0, T, 8'h22);
    chk("R5 gap T accepted", st(0), 256 + 8'h22);

    @(negedge clk); pd_n = 0; wait_n(3);
    chk("R7 sh pd dark", st(0), 0);
    pd_n = 1; wait_n(3);
    chk("R8 dark after release", st(0), 0);
    single(0, 8'h44);
    chk("R8 single edge ignored", st(0), 0);
    wait_n(5);
    single(0, 8'h66);
    chk("R8 second edge updates", st(0), 256 + 8'h66);
    chk("R11 ch1 dark", st(1), 0);

    for (int sh = 0; sh < 2; sh++) begin
      hold_mode = sh[0]; wait_n(3);
      for (int i = 0; i < 20; i++) begin
        int ch = $urandom_range(0, 1);
        int g = $urandom_range(T - 20, T + 20);
        logic [W-1:0] c = W'($urandom_range(0, 255));
        run_pair(ch, g, c);
        chk("R5 random pair", st(ch), exp_pair(g, sh[0], c));
        wait_n($urandom_range(0, 5));
      end
    end

    @(negedge clk); lvl = '0; rst_n = 0; hold_mode = 1; wait_n(3);
    rst_n = 1; wait_n(4);
    chk("R4 sh reset ch0", st(0), 0); chk("R4 sh reset ch1", st(1), 0);
    chk("R9 sh reset ref", ref_en, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule